// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block is a memory-mapped slave. It gives a processor access to the large internal register space of a serial PHY through a narrow control port that uses a handshake. On the host side it has a plain 32-bit register bus: a write strobe, a read strobe, a 6-bit byte offset and the two data words. Host reads are combinational.

On the PHY side the block drives a 16-bit data bus and four strobes: capture-address, capture-data, read and write. It receives a 16-bit return bus and an acknowledge. Software sends a PHY address and then a value through one shared input register, and latches each of them with its own capture command. A final write or read command then performs the access.

Each command is started by writing 1 to its own register. That register reads back 1 while the command is in flight and falls to 0 by itself when the command ends, so software polls it as a busy flag. The first read after a new address may return bad data on the PHY. An optional mode therefore makes the bridge issue two read strobes for one command, discard the first result and keep the second.

Top module: `phy_creg_bridge`

## Requirements
- R1: After synchronous reset, every host register reads 0 and all four PHY strobes are low.
- R2: The data-in register (offset 0x0C) keeps bits 15:0 of a host write and reads back with bits 31:16 as zero. Its value drives the PHY data bus continuously.
- R3: Writing a word with bit 0 set to a command register starts that operation. The command registers are 0x14 capture-address, 0x18 capture-data, 0x1C read and 0x20 write. A word with bit 0 clear has no effect.
- R4: A PHY register write is performed by three commands in order: capture-address, capture-data, write. The PHY then holds the value at that address.
- R5: When bit 0 of the mode register (offset 0x04) is 1, one read command produces two read strobes. Data-out keeps only the second returned value, and the busy bit clears only after the second acknowledge.
- R6: When the mode bit is 0, a read command produces one read strobe, and data-out (offset 0x10) takes the return bus on that acknowledge.
- R7: While a command is in flight, a new command write is ignored. The ignored register reads 0, the active one stays 1, and no further strobe is raised. At most one strobe is high at any time.
- R8: A strobe rises in the cycle after its command is accepted and stays high until the PHY acknowledges. On the acknowledge edge the bridge drops the strobe and clears the busy bit.
- R9: A command register reads 1 (bit 0) while its operation is in flight and 0 otherwise.
- R10: The mode register stores bit 0 of a host write and reads it back in bit 0, with the other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational; 0 when host_re is low) |
| phy_din | output | 16 | Data bus to the PHY (address or value) |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_rd | output | 1 | Register read strobe |
| phy_wr | output | 1 | Register write strobe |
| phy_dout | input | 16 | Return data from the PHY |
| phy_ack | input | 1 | PHY acknowledge of the active strobe |

## Verification
The bench pairs the bridge with a register model of the PHY. That model acknowledges after several cycles, and it returns inverted data on the first read after an address capture. A bridge that skipped the discard read, or that loaded data-out on the first acknowledge, would therefore return the wrong word in double-read mode. The test also sends a second command while the first is still in flight; a bridge that accepted it would raise a write strobe and show a busy bit on the wrong register. Strobes are sampled on the cycles before the acknowledge, to catch a bridge that pulses a strobe for one cycle instead of holding it. The rising edges of the read strobe are counted, to show one read in plain mode and two in double-read mode.

// File: rtl/phy_creg_pkg.sv
package phy_creg_pkg;

    localparam int HOST_W  = 32;
    localparam int OFFS_W  = 6;
    localparam int NUM_OPS = 4;

    // host byte offsets
    localparam logic [OFFS_W-1:0] OFF_MODE = 6'h04;
    localparam logic [OFFS_W-1:0] OFF_DIN  = 6'h0C;
    localparam logic [OFFS_W-1:0] OFF_DOUT = 6'h10;
    localparam logic [OFFS_W-1:0] OFF_CAPA = 6'h14;
    localparam logic [OFFS_W-1:0] OFF_CAPD = 6'h18;
    localparam logic [OFFS_W-1:0] OFF_RD   = 6'h1C;
    localparam logic [OFFS_W-1:0] OFF_WR   = 6'h20;

    typedef enum logic [1:0] {
        OP_CAPA = 2'd0,
        OP_CAPD = 2'd1,
        OP_RD   = 2'd2,
        OP_WR   = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,   // discard read strobe
        ST_GAP  = 2'd2,   // strobe low between the two reads
        ST_MAIN = 2'd3    // strobe that finishes the command
    } seq_state_e;

    typedef struct packed {
        logic    hit;
        cmd_op_e op;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [OFFS_W-1:0] offs);
        cmd_dec_t d;
        d.hit = 1'b1;
        d.op  = OP_CAPA;
        case (offs)
            OFF_CAPA: d.op = OP_CAPA;
            OFF_CAPD: d.op = OP_CAPD;
            OFF_RD:   d.op = OP_RD;
            OFF_WR:   d.op = OP_WR;
            default:  d.hit = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/creg_host_regs.sv
module creg_host_regs
    import phy_creg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [OFFS_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              busy,
    input  cmd_op_e           cur_op,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] data_in,
    output logic              dbl_mode,
    output logic              start,
    output cmd_op_e           start_op,
    output logic [HOST_W-1:0] host_rdata
);

    localparam int PAD_W = HOST_W - DATA_W;

    cmd_dec_t wr_dec;
    cmd_dec_t rd_dec;
    logic     unused_hi;

    assign unused_hi = ^host_wdata[HOST_W-1:DATA_W];
    assign wr_dec    = decode_cmd(host_addr);
    assign rd_dec    = decode_cmd(host_addr);

    assign start    = host_we && wr_dec.hit && host_wdata[0];
    assign start_op = wr_dec.op;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_in  <= '0;
            dbl_mode <= 1'b0;
        end else if (host_we) begin
            if (host_addr == OFF_DIN)  data_in  <= host_wdata[DATA_W-1:0];
            if (host_addr == OFF_MODE) dbl_mode <= host_wdata[0];
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_re) begin
            if (rd_dec.hit) begin
                host_rdata[0] = busy && (cur_op == rd_dec.op);
            end else begin
                case (host_addr)
                    OFF_DIN:  host_rdata = {{PAD_W{1'b0}}, data_in};
                    OFF_DOUT: host_rdata = {{PAD_W{1'b0}}, dout};
                    OFF_MODE: host_rdata[0] = dbl_mode;
                    default:  host_rdata = '0;
                endcase
            end
        end
    end

    // R2
    din_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_we && host_addr == OFF_DIN) |=> $stable(data_in));

endmodule

// File: rtl/creg_seq.sv
module creg_seq
    import phy_creg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  cmd_op_e            start_op,
    input  logic               dbl_mode,
    input  logic               phy_ack,
    input  logic [DATA_W-1:0]  phy_rdata,
    output logic               busy,
    output cmd_op_e            cur_op,
    output logic [NUM_OPS-1:0] strobe_vec,
    output logic [DATA_W-1:0]  dout
);

    seq_state_e state_q;
    cmd_op_e    op_q;
    logic       strobe_on;

    assign busy      = (state_q != ST_IDLE);
    assign cur_op    = op_q;
    assign strobe_on = (state_q == ST_PRE) || (state_q == ST_MAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CAPA;
            dout    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= start_op;
                        state_q <= (start_op == OP_RD && dbl_mode) ? ST_PRE : ST_MAIN;
                    end
                end
                ST_PRE: begin
                    if (phy_ack) state_q <= ST_GAP;
                end
                ST_GAP: begin
                    state_q <= ST_MAIN;
                end
                ST_MAIN: begin
                    if (phy_ack) begin
                        state_q <= ST_IDLE;
                        if (op_q == OP_RD) dout <= phy_rdata;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
        assign strobe_vec[g] = strobe_on && (op_q == cmd_op_e'(g));
    end

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_on && !phy_ack) |=> (strobe_on && $stable(op_q)));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_on && phy_ack) |=> !strobe_on);

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_vec));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q));

    // R5
    discard_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRE) |=> $stable(dout));

endmodule

// File: rtl/phy_creg_bridge.sv
module phy_creg_bridge
    import phy_creg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [5:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic [DATA_W-1:0] phy_din,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_rd,
    output logic              phy_wr,
    input  logic [DATA_W-1:0] phy_dout,
    input  logic              phy_ack
);

    logic               busy;
    cmd_op_e            cur_op;
    logic [DATA_W-1:0]  dout;
    logic [DATA_W-1:0]  data_in;
    logic               dbl_mode;
    logic               start;
    cmd_op_e            start_op;
    logic [NUM_OPS-1:0] strobe_vec;

    creg_host_regs #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_re   (host_re),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .busy      (busy),
        .cur_op    (cur_op),
        .dout      (dout),
        .data_in   (data_in),
        .dbl_mode  (dbl_mode),
        .start     (start),
        .start_op  (start_op),
        .host_rdata(host_rdata)
    );

    creg_seq #(.DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_op  (start_op),
        .dbl_mode  (dbl_mode),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_dout),
        .busy      (busy),
        .cur_op    (cur_op),
        .strobe_vec(strobe_vec),
        .dout      (dout)
    );

    assign phy_din      = data_in;
    assign phy_cap_addr = strobe_vec[OP_CAPA];
    assign phy_cap_data = strobe_vec[OP_CAPD];
    assign phy_rd       = strobe_vec[OP_RD];
    assign phy_wr       = strobe_vec[OP_WR];

endmodule

// File: tb/phy_creg_bridge_tb_top.sv
module phy_creg_bridge_tb_top;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] phy_din;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic [15:0] phy_dout;
    logic        phy_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    phy_creg_bridge dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_dout(phy_dout), .phy_ack(phy_ack)
    );

    // ---------------- PHY register model ----------------
    logic [15:0] mem [64];
    logic [15:0] m_addr, m_data;
    logic        fresh;
    int          cnt;
    logic        strb;
    assign strb = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            m_addr <= '0; m_data <= '0; fresh <= 1'b0;
            cnt <= 0; phy_ack <= 1'b0; phy_dout <= '0;
        end else if (phy_ack) begin
            phy_ack <= 1'b0;
        end else if (strb) begin
            if (cnt == LAT - 1) begin
                cnt     <= 0;
                phy_ack <= 1'b1;
                if (phy_cap_addr) begin m_addr <= phy_din; fresh <= 1'b1; end
                if (phy_cap_data) m_data <= phy_din;
                if (phy_wr) mem[m_addr[5:0]] <= m_data;
                if (phy_rd) begin
                    phy_dout <= fresh ? ~mem[m_addr[5:0]] : mem[m_addr[5:0]];
                    fresh    <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // strobe rise counters
    int   rd_rises = 0, wr_rises = 0;
    logic rd_prev = 1'b0, wr_prev = 1'b0;
    always_ff @(posedge clk) begin
        rd_prev <= phy_rd;
        wr_prev <= phy_wr;
        if (phy_rd && !rd_prev) rd_rises <= rd_rises + 1;
        if (phy_wr && !wr_prev) wr_rises <= wr_rises + 1;
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [31:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, a, e);
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic hw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        #1 d = host_rdata;
        host_re = 1'b0;
    endtask

    task automatic wait_idle(input logic [5:0] a, input string req);
        logic [31:0] v;
        v = 32'h1;
        for (int i = 0; i < 60 && v != 0; i++) hr(a, v);
        if (v != 0) check(req, v, 32'h0);
    endtask

    task automatic phy_write(input logic [15:0] ad, input logic [15:0] val);
        hw(6'h0C, {16'h0, ad}); hw(6'h14, 32'h1); wait_idle(6'h14, "R4");
        hw(6'h0C, {16'h0, val}); hw(6'h18, 32'h1); wait_idle(6'h18, "R4");
        hw(6'h20, 32'h1); wait_idle(6'h20, "R4");
    endtask

    task automatic push_read(input logic [15:0] exp, input string req);
        logic [31:0] v;
        hw(6'h1C, 32'h1); wait_idle(6'h1C, req);
        hr(6'h10, v);
        exp_q.push_back({16'h0, exp});
        tag_q.push_back(req);
        act_q.push_back(v);
    endtask

    task automatic capture_addr(input logic [15:0] ad);
        hw(6'h0C, {16'h0, ad}); hw(6'h14, 32'h1); wait_idle(6'h14, "R3");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin : main
        logic [31:0] v;
        int n0, w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hr(6'h0C, v); check("R1 din", v, 0);
        hr(6'h10, v); check("R1 dout", v, 0);
        hr(6'h04, v); check("R1 mode", v, 0);
        hr(6'h1C, v); check("R1 rd", v, 0);
        check("R1 strobes", {28'h0, phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 0);

        // R2 data-in width and drive
        hw(6'h0C, 32'hABCD_1234);
        hr(6'h0C, v); check("R2 readback", v, 32'h0000_1234);
        check("R2 phy_din", {16'h0, phy_din}, 32'h1234);

        // R10 mode register
        hw(6'h04, 32'hFFFF_FFFF);
        hr(6'h04, v); check("R10 set", v, 32'h1);
        hw(6'h04, 32'h0);
        hr(6'h04, v); check("R10 clear", v, 32'h0);

        // R8 / R9 strobe held until ack; R7 command while busy ignored
        hw(6'h0C, 32'h1010);
        w0 = wr_rises;
        hw(6'h14, 32'h1);
        check("R8 strobe up", {31'h0, phy_cap_addr & ~phy_ack}, 1);
        hw(6'h20, 32'h1);                 // issued while capture-address busy
        check("R8 strobe held", {31'h0, phy_cap_addr}, 1);
        hr(6'h20, v); check("R7 ignored reads 0", v, 0);
        hr(6'h14, v); check("R9 busy reads 1", v, 1);
        wait_idle(6'h14, "R9");
        repeat (LAT + 2) @(negedge clk);
        check("R7 no write strobe", wr_rises, w0);

        // R3 write of zero has no effect
        n0 = rd_rises;
        hw(6'h1C, 32'h0);
        hr(6'h1C, v); check("R3 zero no busy", v, 0);
        repeat (LAT + 2) @(negedge clk);
        check("R3 zero no strobe", rd_rises, n0);

        // R4 PHY register writes
        phy_write(16'h1002, 16'h5A3C);
        phy_write(16'h1006, 16'h0F0F);
        phy_write(16'h1010, 16'h00A0);
        phy_write(16'h102D, 16'hC381);

        // R5 double read
        hw(6'h04, 32'h1);
        capture_addr(16'h1002);
        n0 = rd_rises;
        push_read(16'h5A3C, "R5 dbl 1002");
        check("R5 two strobes", rd_rises - n0, 2);
        capture_addr(16'h102D);
        push_read(16'hC381, "R5 dbl 102D");
        capture_addr(16'h1010);
        push_read(16'h00A0, "R5 dbl 1010");

        // R6 single read: first is the glitched value, second is correct
        hw(6'h04, 32'h0);
        capture_addr(16'h1006);
        n0 = rd_rises;
        push_read(16'hF0F0, "R6 first read");
        check("R6 one strobe", rd_rises - n0, 1);
        push_read(16'h0F0F, "R6 second read");

        repeat (4) @(negedge clk);
        check("R8 idle strobes", {28'h0, phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 0);
        finish_run();
    end

endmodule